// File: doc/BRIEF.md
# Triggered Shadow-Register Update Controller

This block keeps six 8-bit converter setpoints in two stages. Register writes arrive through a decoded port with an address, data and strobe, which an upstream serial-bus slave drives. Each setpoint first lands in a pending (shadow) copy. The value seen on the parallel outputs changes only when a commit condition occurs. Because of this, new settings can be applied at a chosen moment instead of one at a time as they arrive.

A commit can come from several sources:
- Software trigger bits written over the bus.
- An asynchronous external pin, with a programmable active edge and a mask.
- A group mode: when all software triggers are masked, writing the third or sixth setpoint commits its half of the bank.
- A selectable setpoint whose write commits the whole bank.

A two-bit power-mode field is held and presented to neighbouring logic. It has no effect inside the block.

Top module: `trig_commit_ctrl`

## Requirements
- R1: After reset, all six outputs and `pwrMode` are 0. Bus triggers are selected, the external pin is masked with a rising active edge, and all three trigger masks are clear.
- R2: A write to address 0x00..0x05 (setpoints A..F in that order) updates only the pending copy when no commit condition applies. The outputs do not change.
- R3: In bus-trigger mode, writing 1 to bit k (k = 0..2) of address 0x1C while trigger-mask bit 3+k is clear commits all six pending values on the second clock edge after the write, all on the same edge. The trigger bit clears itself, so later writes stay pending.
- R4: A software trigger bit whose mask bit (0x1C bits 5:3 for triggers 2..0) is set has no effect, as long as at least one mask is clear.
- R5: When a setpoint is written several times before a commit, the most recent value is committed.
- R6: In bus-trigger mode with all three masks set, a write to setpoint C (0x02) commits A, B and C on its own clock edge, and a write to setpoint F (0x05) commits D, E and F. The other group is unchanged.
- R7: Address 0x12 bit 3 enables, and bits 2:0 pick, one setpoint (codes 0..5). A write to that setpoint commits all six on its own edge. Codes 6 and 7 commit nothing.
- R8: With address 0x11 bit 4 = 0 (pin mode) and bit 0 = 0 (pin unmasked), an active pin edge commits all six pending values on the third clock edge after the pin changes. Bit 1 = 1 selects rising edges and bit 1 = 0 selects falling edges. The opposite edge does nothing.
- R9: In pin mode, a masked pin (0x11 bit 0 = 1) commits nothing, and software trigger bits have no effect.
- R10: In bus-trigger mode (0x11 bit 4 = 1), edges on the external pin commit nothing.
- R11: Bits 7:6 of a write to 0x1C appear on `pwrMode` after that clock edge and do not change the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W (5) | Register address |
| wrData | input | DATA_W (8) | Register write data |
| extTrig | input | 1 | Asynchronous external trigger pin |
| dacOut | output | 6*DATA_W (48) | Committed setpoints, A in bits 7:0 through F in bits 47:40 |
| pwrMode | output | 2 | Stored power-mode field |

## Verification
Each result has a fixed latency:
- Direct commits (group mode and the selected setpoint) and the power-mode field change on the clock edge that takes the write.
- Software triggers act one edge later, because the trigger bit is registered first.
- Pin edges act on the third edge after the pin moves, after two synchronizer stages and an edge-detect register.

The driver tags every expected output word with the cycle in which it is due, counted from the edge-aligned cycle counter at the moment the stimulus is driven. The monitor compares only in that cycle, a quarter period after the edge. For trigger paths, the unchanged value is checked one cycle before the commit is due, so a commit that arrives early is reported as well.

// File: rtl/trig_commit_pkg.sv
package trig_commit_pkg;
  // bank geometry
  localparam int DAC_CNT  = 6;
  localparam int GRP_SZ   = DAC_CNT / 2;
  localparam int TRIG_CNT = 3;

  // register addresses that the decoder recognises
  localparam int ADR_CFG  = 'h11;
  localparam int ADR_LAST = 'h12;
  localparam int ADR_TRIG = 'h1C;

  localparam logic [DAC_CNT-1:0] LOW_GRP = DAC_CNT'((1 << GRP_SZ) - 1);

  // strobes from control to datapath
  typedef struct packed {
    logic [DAC_CNT-1:0] load;    // write pending copy of setpoint i
    logic [DAC_CNT-1:0] commit;  // copy pending (or forwarded) value to output i
  } dac_cmd_t;
endpackage

// File: rtl/trig_commit_decode.sv
module trig_commit_decode
  import trig_commit_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              extTrig,
  output dac_cmd_t          cmd,
  output logic [1:0]        pwrMode
);
  logic                busSel, edgeRise, pinMask, lastEn;
  logic [2:0]          lastIdx;
  logic [TRIG_CNT-1:0] trigMask, swPend;
  logic [1:0]          pwrReg;
  logic [2:0]          pinSync;   // [0],[1] synchronizer, [2] previous level

  logic dacWr, pinRise, pinFall, pinFire, swFire, lastFire, groupMode;

  always_comb begin
    dacWr     = wrEn && (int'(wrAddr) < DAC_CNT);
    pinRise   = pinSync[1] & ~pinSync[2];
    pinFall   = ~pinSync[1] & pinSync[2];
    pinFire   = !busSel && !pinMask && (edgeRise ? pinRise : pinFall);
    swFire    = busSel && |(swPend & ~trigMask);
    lastFire  = lastEn && dacWr && (int'(lastIdx) < DAC_CNT) &&
                (int'(wrAddr) == int'(lastIdx));
    groupMode = busSel && (&trigMask);

    for (int i = 0; i < DAC_CNT; i++) begin
      cmd.load[i] = dacWr && (int'(wrAddr) == i);
    end

    cmd.commit = '0;
    if (swFire || pinFire || lastFire) begin
      cmd.commit = '1;
    end else if (groupMode && dacWr) begin
      if (int'(wrAddr) == GRP_SZ - 1)       cmd.commit = LOW_GRP;
      else if (int'(wrAddr) == DAC_CNT - 1) cmd.commit = ~LOW_GRP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busSel   <= 1'b1;
      edgeRise <= 1'b1;
      pinMask  <= 1'b1;
      lastEn   <= 1'b0;
      lastIdx  <= '0;
      trigMask <= '0;
      swPend   <= '0;
      pwrReg   <= '0;
      pinSync  <= '0;
    end else begin
      pinSync <= {pinSync[1:0], extTrig};
      swPend  <= '0;
      if (wrEn && int'(wrAddr) == ADR_CFG) begin
        busSel   <= wrData[4];
        edgeRise <= wrData[1];
        pinMask  <= wrData[0];
      end
      if (wrEn && int'(wrAddr) == ADR_LAST) begin
        lastEn  <= wrData[3];
        lastIdx <= wrData[2:0];
      end
      if (wrEn && int'(wrAddr) == ADR_TRIG) begin
        pwrReg   <= wrData[7:6];
        trigMask <= wrData[5:3];
        swPend   <= wrData[2:0];
      end
    end
  end

  assign pwrMode = pwrReg;
endmodule

// File: rtl/trig_commit_regs.sv
module trig_commit_regs
  import trig_commit_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dac_cmd_t                  cmd,
  input  logic [DATA_W-1:0]         wrData,
  output logic [DAC_CNT*DATA_W-1:0] dacOut
);
  for (genvar g = 0; g < DAC_CNT; g++) begin : g_dac
    logic [DATA_W-1:0] pendVal, liveVal;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendVal <= '0;
        liveVal <= '0;
      end else begin
        if (cmd.load[g]) pendVal <= wrData;
        // a write on the commit edge is forwarded so the newest value wins
        if (cmd.commit[g]) liveVal <= cmd.load[g] ? wrData : pendVal;
      end
    end

    assign dacOut[g*DATA_W +: DATA_W] = liveVal;
  end
endmodule

// File: rtl/trig_commit_ctrl.sv
module trig_commit_ctrl
  import trig_commit_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [ADDR_W-1:0]         wrAddr,
  input  logic [DATA_W-1:0]         wrData,
  input  logic                      extTrig,
  output logic [DAC_CNT*DATA_W-1:0] dacOut,
  output logic [1:0]                pwrMode
);
  dac_cmd_t cmd;

  trig_commit_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .extTrig(extTrig), .cmd(cmd), .pwrMode(pwrMode)
  );

  trig_commit_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrData(wrData), .dacOut(dacOut)
  );
endmodule

// File: rtl/trig_commit_chk.sv
module trig_commit_chk
  import trig_commit_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      wrEn,
  input logic [ADDR_W-1:0]         wrAddr,
  input logic [DATA_W-1:0]         wrData,
  input dac_cmd_t                  cmd,
  input logic [DAC_CNT*DATA_W-1:0] dacOut,
  input logic [1:0]                pwrMode
);
  // R2: outputs move only when the control raises a commit strobe
  a_r2_hold_without_commit: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.commit == '0) |=> $stable(dacOut));

  // R2: a write reaches at most one pending register
  a_r2_single_load: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmd.load));

  // R6: commits cover the whole bank or exactly one half
  a_r6_commit_shape: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.commit == '0) || (cmd.commit == '1) ||
    (cmd.commit == LOW_GRP) || (cmd.commit == ~LOW_GRP));

  // R11: the power field changes only on a write to the trigger register
  a_r11_pwr_stable: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && int'(wrAddr) == ADR_TRIG) |=> $stable(pwrMode));

  // R5: a setpoint written on its commit edge reaches the output
  for (genvar g = 0; g < DAC_CNT; g++) begin : g_fwd
    a_r5_commit_takes_write: assert property (@(posedge clk) disable iff (!rstN)
      (cmd.load[g] && cmd.commit[g]) |=> dacOut[g*DATA_W +: DATA_W] == $past(wrData));
  end
endmodule

bind trig_commit_ctrl trig_commit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .cmd(cmd), .dacOut(dacOut), .pwrMode(pwrMode)
);

// File: tb/sim_trig_commit_ctrl.sv
module sim_trig_commit_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        extTrig = 1'b0;
  logic [47:0] dacOut;
  logic [1:0]  pwrMode;

  trig_commit_ctrl u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .extTrig(extTrig), .dacOut(dacOut), .pwrMode(pwrMode)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct {
    int          due;
    string       req;
    logic [49:0] exp;
  } item_t;

  item_t       q[$];
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;
  logic [1:0]  expPm = '0;
  logic [47:0] cur = '0;
  logic [47:0] prev = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [47:0] pk(input logic [7:0] a, b, c, d, e, f);
    return {f, e, d, c, b, a};
  endfunction

  task automatic push(input int due, input string req, input logic [47:0] e);
    item_t it;
    it.due = due;
    it.req = req;
    it.exp = {expPm, e};
    q.push_back(it);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d, input string req,
                    input int lat, input logic [47:0] e);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    push(cyc + lat, req, e);
    @(posedge clk);
    #(CLK_P/4);
    wrEn = 1'b0;
  endtask

  // trigger write: unchanged one edge after, committed two edges after
  task automatic wr2(input logic [4:0] a, input logic [7:0] d, input string req,
                     input logic [47:0] e1, input logic [47:0] e2);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    push(cyc + 1, req, e1);
    push(cyc + 2, req, e2);
    @(posedge clk);
    #(CLK_P/4);
    wrEn = 1'b0;
  endtask

  // pin change: unchanged on edge two, result due on edge three
  task automatic pin(input logic v, input string req,
                     input logic [47:0] e1, input logic [47:0] e2);
    @(negedge clk);
    extTrig = v;
    push(cyc + 2, req, e1);
    push(cyc + 3, req, e2);
    repeat (4) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // monitor: compare every item that falls due in this cycle
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].due <= cyc) begin
          checks++;
          if ({pwrMode, dacOut} !== q[i].exp || q[i].due < cyc) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)",
                     q[i].req, {pwrMode, dacOut}, q[i].exp, cyc);
          end
          q.delete(i);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    push(cyc + 1, "R1 reset state", cur);
    idle(2);

    // R2: writes held in the pending copies
    wr(5'h00, 8'h11, "R2", 1, cur);
    wr(5'h01, 8'h22, "R2", 1, cur);
    wr(5'h02, 8'h33, "R2", 1, cur);
    wr(5'h03, 8'h44, "R2", 1, cur);
    wr(5'h04, 8'h55, "R2", 1, cur);
    wr(5'h05, 8'h66, "R2", 1, cur);
    wr(5'h00, 8'h10, "R5 rewrite", 1, cur);

    // R3 / R5: software trigger 0 commits newest values
    prev = cur; cur = pk(8'h10, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66);
    wr2(5'h1C, 8'h01, "R3 R5 sw trigger", prev, cur);
    idle(1);
    wr(5'h01, 8'h77, "R3 self-clear", 1, cur);
    idle(2);
    push(cyc + 1, "R3 self-clear", cur);
    idle(1);

    // R4: trigger 0 masked, others clear
    wr2(5'h1C, 8'h09, "R4 masked trigger", cur, cur);
    idle(1);
    prev = cur; cur[15:8] = 8'h77;
    wr2(5'h1C, 8'h0A, "R3 trigger 1", prev, cur);
    idle(1);

    // R11: power field
    expPm = 2'd3;
    wr(5'h1C, 8'hC0, "R11 power mode", 1, cur);

    // R6: group mode
    wr(5'h1C, 8'hF8, "R6 enter group", 1, cur);
    wr(5'h00, 8'hA1, "R6", 1, cur);
    wr(5'h01, 8'hA2, "R6", 1, cur);
    wr(5'h03, 8'hA4, "R6", 1, cur);
    cur = pk(8'hA1, 8'hA2, 8'hA3, 8'h44, 8'h55, 8'h66);
    wr(5'h02, 8'hA3, "R6 low group", 1, cur);
    wr(5'h04, 8'hA5, "R6", 1, cur);
    cur = pk(8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'hA6);
    wr(5'h05, 8'hA6, "R6 high group", 1, cur);
    wr(5'h1C, 8'hC0, "R6 leave group", 1, cur);

    // R7: selected setpoint commits the bank
    wr(5'h12, 8'h0B, "R7", 1, cur);
    wr(5'h00, 8'hB1, "R7", 1, cur);
    cur = pk(8'hB1, 8'hA2, 8'hA3, 8'hB4, 8'hA5, 8'hA6);
    wr(5'h03, 8'hB4, "R7 select hit", 1, cur);
    wr(5'h12, 8'h0E, "R7", 1, cur);
    wr(5'h05, 8'hB6, "R7 code 6", 1, cur);
    wr(5'h00, 8'hB0, "R7", 1, cur);
    wr(5'h12, 8'h00, "R7", 1, cur);

    // R8 / R9: pin mode, rising edge
    wr(5'h11, 8'h02, "R8", 1, cur);
    wr2(5'h1C, 8'hC1, "R9 sw trigger in pin mode", cur, cur);
    idle(1);
    prev = cur; cur = pk(8'hB0, 8'hA2, 8'hA3, 8'hB4, 8'hA5, 8'hB6);
    pin(1'b1, "R8 rising", prev, cur);
    wr(5'h01, 8'hC2, "R8", 1, cur);
    pin(1'b0, "R8 opposite edge", cur, cur);

    // R8: falling edge selected
    wr(5'h11, 8'h00, "R8", 1, cur);
    pin(1'b1, "R8 opposite edge", cur, cur);
    prev = cur; cur[15:8] = 8'hC2;
    pin(1'b0, "R8 falling", prev, cur);

    // R9: masked pin
    wr(5'h11, 8'h01, "R9", 1, cur);
    wr(5'h02, 8'hC3, "R9", 1, cur);
    pin(1'b1, "R9 masked pin", cur, cur);
    pin(1'b0, "R9 masked pin", cur, cur);

    // R10: bus mode ignores the pin
    wr(5'h11, 8'h12, "R10", 1, cur);
    pin(1'b1, "R10 pin in bus mode", cur, cur);
    pin(1'b0, "R10 pin in bus mode", cur, cur);
    prev = cur; cur[23:16] = 8'hC3;
    wr2(5'h1C, 8'hC4, "R3 trigger 2", prev, cur);
    idle(4);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule